// File: doc/BRIEF.md
# Serial Channel Status and Modem-Change Register

This block is the status word of one serial channel. It brings in the four modem control inputs from outside the clock domain: carrier detect, data set ready, clear to send and ring indicator. Each input is synchronized, and the block shows its current level. Any toggle of a synchronized line sets a sticky change flag, which stays set until software clears it.

The same word also carries three conditions that come from the neighbouring FIFO logic:
- receive data available, shown as a live level;
- receive overrun, shown as a live level;
- transmit empty, held as a sticky flag that is set when the transmit count falls to zero.

Only the sticky bits clear when software writes a one to them. Software can therefore write back the exact value it read, and only the events it has seen are cleared. Three enable bits in a control word decide which conditions drive the channel's interrupt request.

Top module: `uart_chan_status`

## Requirements
- R1: Status bit 3 shows synchronized carrier detect, bit 4 data set ready, bit 5 clear to send and bit 6 ring indicator. Each bit reflects its input as sampled two clock edges earlier. Bit 0 follows `rx_avail_i` and bit 13 follows `rx_ovr_i` in the same cycle.
- R2: A rising or falling edge on a synchronized modem line sets its change flag one edge after the level bit changes. The flag positions are bit 16 (data set ready), bit 17 (clear to send), bit 18 (carrier detect) and bit 22 (ring indicator). A flag stays set until it is cleared.
- R3: A status write with a one at bit 16, 17, 18, 22 or 25 clears that flag at the next edge. Flags whose bit is written as zero keep their value.
- R4: A status write has no effect on the live bits 0, 3, 4, 5, 6 and 13. Writing back a value that was read clears only the flags that were set in it.
- R5: When a flag is set and cleared in the same cycle, the set takes effect and the flag ends up set.
- R6: Bit 25 (transmit empty) is set one edge after `tx_cnt_i` goes from a nonzero value to zero. It is sticky and clears only by writing one to bit 25.
- R7: A control write loads three enables: bit 0 for modem status, bit 2 for receive and bit 19 for transmit. All other control bits are ignored, and the enables hold their value between writes.
- R8: `irq_o` is high exactly when at least one of these holds: (any modem change flag set AND modem enable), (bit 0 set AND receive enable), or (bit 25 set AND transmit enable).
- R9: Reset clears all change flags, transmit empty, all enables and the synchronizers. With inputs low, the status word reads zero and `irq_o` is low.
- R10: Status bits outside 0, 3 to 6, 13, 16 to 18, 22 and 25 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dcd_i | input | 1 | Carrier detect line, asynchronous |
| dsr_i | input | 1 | Data set ready line, asynchronous |
| cts_i | input | 1 | Clear to send line, asynchronous |
| ri_i | input | 1 | Ring indicator line, asynchronous |
| rx_avail_i | input | 1 | Receive FIFO holds data |
| rx_ovr_i | input | 1 | Receive overrun condition |
| tx_cnt_i | input | TXCNT_W | Bytes waiting in the transmit FIFO |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 32 | Control word write data |
| stat_we_i | input | 1 | Status word write strobe |
| stat_wdata_i | input | 32 | Status word write data, one clears a flag |
| stat_o | output | 32 | Status word |
| irq_o | output | 1 | Channel interrupt request |

## Verification
The assertions assume that `rx_avail_i`, `rx_ovr_i` and `tx_cnt_i` are synchronous to `clk`, and that the modem lines are low while reset is asserted. They also assume that any modem-line change is caught by the two flops before edge detection. The bench changes every input only at the falling clock edge. It holds all inputs low through reset and randomizes them only after reset is released. In the random phase, modem toggles and status writes are spread out so that sets, clears and collisions all occur.

// File: rtl/uart_chan_status.sv
module uart_chan_status #(
  parameter int TXCNT_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dcd_i,
  input  logic               dsr_i,
  input  logic               cts_i,
  input  logic               ri_i,
  input  logic               rx_avail_i,
  input  logic               rx_ovr_i,
  input  logic [TXCNT_W-1:0] tx_cnt_i,
  input  logic               ctl_we_i,
  input  logic [31:0]        ctl_wdata_i,
  input  logic               stat_we_i,
  input  logic [31:0]        stat_wdata_i,
  output logic [31:0]        stat_o,
  output logic               irq_o
);
  localparam int B_RXD  = 0;
  localparam int B_DCD  = 3;
  localparam int B_DSR  = 4;
  localparam int B_CTS  = 5;
  localparam int B_RI   = 6;
  localparam int B_OVR  = 13;
  localparam int B_DSRC = 16;
  localparam int B_CTSC = 17;
  localparam int B_DCDC = 18;
  localparam int B_RIC  = 22;
  localparam int B_TXE  = 25;
  localparam int E_MS   = 0;
  localparam int E_RX   = 2;
  localparam int E_TX   = 19;

  // line order inside the vectors: 0 carrier, 1 set ready, 2 clear to send, 3 ring
  logic [3:0] line_in, sync_a, sync_b, sync_c, chg_q, chg_set, chg_clr;
  logic       txe_q, tx_nz_q, txe_set, txe_clr;
  logic       en_ms, en_rx, en_tx;

  assign line_in = {ri_i, cts_i, dsr_i, dcd_i};
  assign chg_set = sync_b ^ sync_c;
  assign chg_clr = stat_we_i ? {stat_wdata_i[B_RIC], stat_wdata_i[B_CTSC],
                                stat_wdata_i[B_DSRC], stat_wdata_i[B_DCDC]} : 4'b0;
  assign txe_set = tx_nz_q && (tx_cnt_i == '0);
  assign txe_clr = stat_we_i && stat_wdata_i[B_TXE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a  <= '0;
      sync_b  <= '0;
      sync_c  <= '0;
      chg_q   <= '0;
      txe_q   <= 1'b0;
      tx_nz_q <= 1'b0;
    end else begin
      sync_a  <= line_in;
      sync_b  <= sync_a;
      sync_c  <= sync_b;
      chg_q   <= (chg_q & ~chg_clr) | chg_set;
      txe_q   <= (txe_q & ~txe_clr) | txe_set;
      tx_nz_q <= (tx_cnt_i != '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_ms <= 1'b0;
      en_rx <= 1'b0;
      en_tx <= 1'b0;
    end else if (ctl_we_i) begin
      en_ms <= ctl_wdata_i[E_MS];
      en_rx <= ctl_wdata_i[E_RX];
      en_tx <= ctl_wdata_i[E_TX];
    end
  end

  always_comb begin
    stat_o         = '0;
    stat_o[B_RXD]  = rx_avail_i;
    stat_o[B_DCD]  = sync_b[0];
    stat_o[B_DSR]  = sync_b[1];
    stat_o[B_CTS]  = sync_b[2];
    stat_o[B_RI]   = sync_b[3];
    stat_o[B_OVR]  = rx_ovr_i;
    stat_o[B_DCDC] = chg_q[0];
    stat_o[B_DSRC] = chg_q[1];
    stat_o[B_CTSC] = chg_q[2];
    stat_o[B_RIC]  = chg_q[3];
    stat_o[B_TXE]  = txe_q;
  end

  assign irq_o = ((|chg_q) & en_ms) | (rx_avail_i & en_rx) | (txe_q & en_tx);

  // R1
  level_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_a == line_in |=> stat_o[B_DCD] == $past(sync_a[0]));

  // R2
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((chg_q & $past(chg_q & ~chg_clr)) == $past(chg_q & ~chg_clr)));

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_set != 4'b0 |=> ((chg_q & $past(chg_set)) == $past(chg_set)));

  // R6
  txe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txe_q) |-> $past(tx_cnt_i) == '0);

  // R7
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we_i |=> $stable({en_ms, en_rx, en_tx}));

  // R8
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((|chg_q) || rx_avail_i || txe_q));
endmodule

// File: tb/uart_chan_status_tb_top.sv
`timescale 1ns/1ps
module uart_chan_status_tb_top;
  localparam int TW = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic dcd = 0, dsr = 0, cts = 0, ri = 0, rxa = 0, ovr = 0;
  logic [TW-1:0] txc = '0;
  logic cwe = 0, swe = 0;
  logic [31:0] cwd = '0, swd = '0;
  logic [31:0] stat;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  logic [3:0] m1 = 0, m2 = 0, m3 = 0, mchg = 0;
  logic mtxe = 0, mnz = 0, mms = 0, mrx = 0, mtx = 0;

  always #2.5 clk = ~clk;

  uart_chan_status #(.TXCNT_W(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .dcd_i(dcd), .dsr_i(dsr), .cts_i(cts), .ri_i(ri),
    .rx_avail_i(rxa), .rx_ovr_i(ovr), .tx_cnt_i(txc), .ctl_we_i(cwe),
    .ctl_wdata_i(cwd), .stat_we_i(swe), .stat_wdata_i(swd),
    .stat_o(stat), .irq_o(irq));

  function automatic logic [31:0] exp_stat();
    logic [31:0] s = '0;
    s[0] = rxa; s[13] = ovr;
    s[3] = m2[0]; s[4] = m2[1]; s[5] = m2[2]; s[6] = m2[3];
    s[18] = mchg[0]; s[16] = mchg[1]; s[17] = mchg[2]; s[22] = mchg[3];
    s[25] = mtxe;
    return s;
  endfunction

  function automatic logic exp_irq();
    return ((|mchg) && mms) || (rxa && mrx) || (mtxe && mtx);
  endfunction

  task automatic check(string tag);
    logic [31:0] es = exp_stat();
    logic ei = exp_irq();
    checks++;
    if (stat !== es) begin
      fails++;
      $display("FAIL %s status got %h expected %h", tag, stat, es);
    end
    checks++;
    if (irq !== ei) begin
      fails++;
      $display("FAIL %s irq got %b expected %b", tag, irq, ei);
    end
  endtask

  task automatic model_edge();
    logic [3:0] clr = swe ? {swd[22], swd[17], swd[16], swd[18]} : 4'b0;
    logic [3:0] set = m2 ^ m3;
    logic tset = mnz && (txc == '0);
    mchg = (mchg & ~clr) | set;
    mtxe = (mtxe & ~(swe && swd[25])) | tset;
    mnz = (txc != '0);
    m3 = m2; m2 = m1; m1 = {ri, cts, dsr, dcd};
    if (cwe) begin mms = cwd[0]; mrx = cwd[2]; mtx = cwd[19]; end
  endtask

  // inputs already set after a falling edge; advance one clock and check
  task automatic step(string tag);
    @(posedge clk);
    model_edge();
    #1 check(tag);
    @(negedge clk);
    cwe = 0; swe = 0;
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R9 reset");
    rst_n = 1'b1;
    idle(3, "R9 after reset");

    dcd = 1; idle(2, "R1 carrier level");
    dsr = 1; cts = 1; idle(4, "R2 edge flags");
    ri = 1; idle(2, "R1 ring level"); ri = 0; idle(4, "R2 pulse both edges");
    rxa = 1; ovr = 1; idle(1, "R1 fifo levels");

    swe = 1; swd = 32'h0001_0000; step("R3 clear one flag");
    idle(1, "R3 others kept");
    swe = 1; swd = stat; step("R4 write back");
    swe = 1; swd = 32'hFFBB_DF86; step("R4 live bits untouched");
    idle(1, "R10 unused zero");

    cts = 0; @(posedge clk); model_edge(); #1 check("R5 pre"); @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      swe = 1; swd = 32'hFFFF_FFFF; step("R5 set beats clear");
    end
    idle(1, "R5 flag kept");

    txc = 10'd5; idle(2, "R6 count nonzero");
    txc = 10'd0; idle(2, "R6 empty set");
    txc = 10'd0; idle(2, "R6 sticky");
    swe = 1; swd = 32'h0200_0000; step("R6 clear");
    idle(2, "R6 stays clear at zero");

    cwe = 1; cwd = 32'hFFF7_FFFA; step("R7 others ignored");
    cwe = 1; cwd = 32'h0000_0004; step("R8 rx enable");
    rxa = 0; idle(1, "R8 rx gone");
    cwe = 1; cwd = 32'h0000_0001; step("R8 modem enable");
    swe = 1; swd = 32'h0047_0000; step("R8 flags cleared");
    txc = 3; idle(1, "R8 tx"); txc = 0;
    cwe = 1; cwd = 32'h0008_0000; step("R8 tx enable");
    idle(1, "R7 hold");

    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(7) == 0) {ri, cts, dsr, dcd} = 4'($urandom());
      rxa = 1'($urandom()); ovr = 1'($urandom());
      if ($urandom_range(3) == 0) txc = TW'($urandom_range(3));
      if ($urandom_range(5) == 0) begin swe = 1; swd = $urandom(); end
      if ($urandom_range(15) == 0) begin cwe = 1; cwd = $urandom(); end
      step("R10 random mix");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #150000;
    if (!done) begin
      fails++;
      $display("FAIL R9 watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule